// File: doc/BRIEF.md
# I2C Bus-Busy Monitor

This block observes the two open-drain lines of a multi-master I2C bus and tells a local master when it may begin a transfer. It synchronizes SCL and SDA into the system clock domain and finds START and STOP conditions on the synchronized samples. It then tracks whether the bus is held by some master. After a STOP, the bus counts as free only once a minimum gap, the bus-free time, has elapsed. A START at any point makes the bus busy again.

Right after reset the monitor cannot know whether a transfer is already under way, because it may have missed the START. On a shared bus it therefore starts out busy. It is released either by a STOP followed by the gap, or by both lines staying high for a long idle window. A mode input marks the bus as not shared. In that mode the uncertainty check is skipped and the bus counts as free from reset. Both intervals are parameters counted in system clock cycles. With a 100 MHz clock, the 4.7 us gap is 470 cycles and the 4 ms idle window is 400000 cycles.

Top module: `i2c_busy_monitor`

## Requirements
- R1: With `shared_mode_i` = 1, `bus_free_o` is 0 during reset and stays 0 after reset until one of the release paths in R6 or R8 completes.
- R2: With `shared_mode_i` = 0, `bus_free_o` is 1 during reset and remains 1 after reset until a START is seen.
- R3: A START (synchronized SDA going 1 to 0 while synchronized SCL stays 1) drives `bus_free_o` to 0 after the third rising clock edge that follows the SDA change at the pins.
- R4: A STOP (synchronized SDA going 0 to 1 while synchronized SCL stays 1) seen while busy starts the gap. `bus_free_o` rises after rising edge 3+TBUF_CYCLES counted from the SDA change at the pins. A further STOP during the gap restarts the count.
- R5: A START during the gap cancels it, and `bus_free_o` stays 0.
- R6: In the post-reset uncertain state with `shared_mode_i` = 1, `bus_free_o` rises once both synchronized lines have been high for IDLE_CYCLES consecutive cycles.
- R7: A low level on either line during the idle window restarts the window from zero.
- R8: A STOP seen in the post-reset uncertain state takes the gap path of R4 and does not wait for the idle window.
- R9: SDA changes made while SCL is low neither free nor occupy the bus. Once free, the bus stays free until a START.
- R10: `shared_mode_i` has an effect only in the post-reset uncertain state. Changing it once the bus is busy, in the gap or free leaves `bus_free_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; deasserted synchronously to clk |
| scl_i | input | 1 | Sampled bus clock line (asynchronous) |
| sda_i | input | 1 | Sampled bus data line (asynchronous) |
| shared_mode_i | input | 1 | 1: bus shared with other masters, apply post-reset check; 0: bus free from reset |
| bus_free_o | output | 1 | 1 when a local master may issue a START |

## Verification
The assertions take for granted that the line inputs behave like a real bus: SDA moves only while SCL is low, except at deliberate START and STOP edges. They also assume every level is held for several clock cycles, so both synchronizer flops settle. The stimulus follows this by changing one line per step on a falling clock edge. Between line changes it waits at least two cycles. It changes `shared_mode_i` only while reset is applied or in the settled states named in R10. The gap and idle counters in the checker assume that a STOP arriving during an idle window leaves the uncertain state, which the stimulus exercises.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

  typedef enum logic [1:0] {
    BS_UNKNOWN = 2'd0,
    BS_BUSY    = 2'd1,
    BS_GAP     = 2'd2,
    BS_FREE    = 2'd3
  } bus_state_t;

endpackage

// File: rtl/i2cbm_sync.sv
module i2cbm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d[0] = d_i;

  generate
    for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
      assign chain_d[gi] = chain_q[gi-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2cbm_cond_det.sv
module i2cbm_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic lines_high_o
);

  logic scl_prev_q;
  logic sda_prev_q;
  logic scl_steady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  assign scl_steady   = scl_prev_q & scl_s_i;
  assign start_o      = scl_steady & sda_prev_q & ~sda_s_i;
  assign stop_o       = scl_steady & ~sda_prev_q & sda_s_i;
  assign lines_high_o = scl_s_i & sda_s_i;

endmodule

// File: rtl/i2cbm_interval.sv
module i2cbm_interval #(
  parameter int LIMIT = 470
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign done_o  = run_i & at_last;

  always_comb begin
    if (!run_i)       cnt_d = '0;
    else if (at_last) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
  import i2cbm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TBUF_CYCLES = 470,
  parameter int IDLE_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic shared_mode_i,
  output logic bus_free_o
);

  logic       scl_s;
  logic       sda_s;
  logic       start_det;
  logic       stop_det;
  logic       lines_high;
  logic       gap_run;
  logic       gap_done;
  logic       idle_run;
  logic       idle_done;
  bus_state_t state_q;
  bus_state_t state_d;

  i2cbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) scl_sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
  );

  i2cbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sda_sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
  );

  i2cbm_cond_det cond_i (
    .clk(clk), .rst_n(rst_n),
    .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(start_det), .stop_o(stop_det), .lines_high_o(lines_high)
  );

  // gap timer restarts on every STOP seen inside the gap
  assign gap_run  = (state_q == BS_GAP) & ~stop_det;
  assign idle_run = (state_q == BS_UNKNOWN) & shared_mode_i & lines_high;

  i2cbm_interval #(.LIMIT(TBUF_CYCLES)) gap_tmr_i (
    .clk(clk), .rst_n(rst_n), .run_i(gap_run), .done_o(gap_done)
  );

  i2cbm_interval #(.LIMIT(IDLE_CYCLES)) idle_tmr_i (
    .clk(clk), .rst_n(rst_n), .run_i(idle_run), .done_o(idle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BS_UNKNOWN: begin
        if (start_det)                        state_d = BS_BUSY;
        else if (stop_det)                    state_d = BS_GAP;
        else if (!shared_mode_i || idle_done) state_d = BS_FREE;
      end
      BS_BUSY: begin
        if (stop_det) state_d = BS_GAP;
      end
      BS_GAP: begin
        if (start_det)     state_d = BS_BUSY;
        else if (gap_done) state_d = BS_FREE;
      end
      BS_FREE: begin
        if (start_det) state_d = BS_BUSY;
      end
      default: state_d = BS_UNKNOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BS_UNKNOWN;
    else        state_q <= state_d;
  end

  assign bus_free_o = (state_q == BS_FREE) |
                      ((state_q == BS_UNKNOWN) & ~shared_mode_i);

endmodule

// File: rtl/i2cbm_checker.sv
module i2cbm_checker
  import i2cbm_pkg::*;
#(
  parameter int TBUF_CYCLES = 470,
  parameter int IDLE_CYCLES = 400000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       stop_det,
  input logic       lines_high,
  input logic       shared_mode_i,
  input bus_state_t state_q,
  input logic       bus_free_o
);

  int  gap_cnt;
  int  hi_cnt;
  logic stop_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt   <= 0;
      hi_cnt    <= 0;
      stop_seen <= 1'b0;
    end else begin
      if (stop_det)                 gap_cnt <= 0;
      else if (gap_cnt < TBUF_CYCLES) gap_cnt <= gap_cnt + 1;
      if (!lines_high)              hi_cnt <= 0;
      else if (hi_cnt < IDLE_CYCLES) hi_cnt <= hi_cnt + 1;
      if (stop_det)                 stop_seen <= 1'b1;
    end
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !bus_free_o);

  // R4
  stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !bus_free_o) |=> !bus_free_o);

  // R4
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_free_o) && stop_seen) |-> (gap_cnt >= TBUF_CYCLES));

  // R6
  idle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_free_o) && !stop_seen && shared_mode_i && $past(shared_mode_i))
      |-> (hi_cnt >= IDLE_CYCLES));

  // R9
  free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BS_FREE && !start_det) |=> bus_free_o);

endmodule

bind i2c_busy_monitor i2cbm_checker #(
  .TBUF_CYCLES(TBUF_CYCLES),
  .IDLE_CYCLES(IDLE_CYCLES)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .start_det(start_det),
  .stop_det(stop_det),
  .lines_high(lines_high),
  .shared_mode_i(shared_mode_i),
  .state_q(state_q),
  .bus_free_o(bus_free_o)
);

// File: tb/i2c_busy_monitor_tb.sv
`timescale 1ns/1ps
module i2c_busy_monitor_tb_top;

  localparam int TBUF = 20;
  localparam int IDLE = 150;

  logic clk;
  logic rst_n;
  logic scl;
  logic sda;
  logic shared;
  logic bus_free;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  i2c_busy_monitor #(.SYNC_STAGES(2), .TBUF_CYCLES(TBUF), .IDLE_CYCLES(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .shared_mode_i(shared), .bus_free_o(bus_free)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model: 0 unknown, 1 busy, 2 gap, 3 free
  int         m_st;
  int         m_tcnt;
  int         m_icnt;
  logic [1:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    logic [1:0] cur;
    logic [1:0] prv;
    bit st_ev;
    bit sp_ev;
    bit hi;
    int nst;
    if (!rst_n) begin
      m_st = 0; m_tcnt = 0; m_icnt = 0;
      hist = '{2'b11, 2'b11, 2'b11};
    end else begin
      cur   = hist[1];
      prv   = hist[0];
      st_ev = prv[1] && cur[1] && prv[0] && !cur[0];
      sp_ev = prv[1] && cur[1] && !prv[0] && cur[0];
      hi    = (cur == 2'b11);
      nst   = m_st;
      case (m_st)
        0: if (st_ev) nst = 1;
           else if (sp_ev) nst = 2;
           else if (!shared || (hi && m_icnt == IDLE - 1)) nst = 3;
        1: if (sp_ev) nst = 2;
        2: if (st_ev) nst = 1;
           else if (!sp_ev && m_tcnt == TBUF - 1) nst = 3;
        default: if (st_ev) nst = 1;
      endcase
      m_tcnt = (m_st == 2 && !sp_ev) ? m_tcnt + 1 : 0;
      m_icnt = (m_st == 0 && shared && hi) ? m_icnt + 1 : 0;
      m_st   = nst;
      void'(hist.pop_front());
      hist.push_back({scl, sda});
    end
  end

  function automatic string tag_of(int st, logic sh);
    case (st)
      0: return sh ? "R1/R6" : "R2";
      1: return "R3";
      2: return "R4";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit exp;
    #2;
    if (!done) begin
      exp = (m_st == 3) || (m_st == 0 && !shared);
      checks++;
      if (bus_free !== exp) begin
        errors++;
        $display("FAIL %s model compare t=%0t: got %b expected %b",
                 tag_of(m_st, shared), $time, bus_free, exp);
      end
    end
  end

  task automatic chk(bit exp, string req);
    checks++;
    if (bus_free !== exp) begin
      errors++;
      $display("FAIL %s directed t=%0t: got %b expected %b", req, $time, bus_free, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic sh);
    @(negedge clk);
    rst_n = 1'b0; shared = sh; scl = 1'b1; sda = 1'b1;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic start_cond();
    sda = 1'b0; cyc(3);
  endtask

  task automatic stop_cond();
    scl = 1'b0; cyc(2); sda = 1'b0; cyc(2); scl = 1'b1; cyc(2); sda = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; shared = 1'b1; scl = 1'b1; sda = 1'b1;
    // shared bus: busy out of reset, freed by idle window
    do_reset(1'b1);
    chk(1'b0, "R1");
    cyc(IDLE - 1); chk(1'b0, "R6");
    cyc(1);        chk(1'b1, "R6");
    // START
    start_cond();  chk(1'b0, "R3");
    // data bits with SCL low
    for (int b = 0; b < 4; b++) begin
      scl = 1'b0; cyc(2); sda = b[0]; cyc(2); scl = 1'b1; cyc(3);
      chk(1'b0, "R9");
    end
    scl = 1'b0; cyc(2); sda = 1'b1; cyc(2); scl = 1'b1; cyc(2);
    // STOP and gap
    stop_cond();
    cyc(2 + TBUF); chk(1'b0, "R4");
    cyc(1);        chk(1'b1, "R4");
    // mode change while free has no effect
    shared = 1'b0; cyc(3); chk(1'b1, "R10");
    shared = 1'b1; cyc(3); chk(1'b1, "R10");
    // SDA wiggle under SCL low while free
    scl = 1'b0; cyc(2); sda = 1'b0; cyc(2); sda = 1'b1; cyc(2); scl = 1'b1; cyc(4);
    chk(1'b1, "R9");
    // START during the gap
    start_cond(); stop_cond(); cyc(8);
    start_cond(); chk(1'b0, "R5");
    cyc(TBUF + 5); chk(1'b0, "R5");
    stop_cond(); cyc(3 + TBUF); chk(1'b1, "R4");
    // second STOP inside the gap restarts it
    start_cond(); stop_cond(); cyc(10);
    stop_cond(); cyc(2 + TBUF); chk(1'b0, "R4");
    cyc(1); chk(1'b1, "R4");

    // idle window restarted by a low SCL
    do_reset(1'b1);
    cyc(100); scl = 1'b0; cyc(3); scl = 1'b1;
    cyc(IDLE - 90); chk(1'b0, "R7");
    cyc(120); chk(1'b1, "R7");

    // STOP in the uncertain state
    do_reset(1'b1);
    cyc(10); stop_cond();
    cyc(2 + TBUF); chk(1'b0, "R8");
    cyc(1);        chk(1'b1, "R8");

    // non-shared mode: free from reset
    @(negedge clk);
    rst_n = 1'b0; shared = 1'b0; scl = 1'b1; sda = 1'b1;
    cyc(1); chk(1'b1, "R2");
    cyc(2); rst_n = 1'b1;
    cyc(1); chk(1'b1, "R2");
    cyc(5); chk(1'b1, "R2");
    start_cond(); chk(1'b0, "R3");
    shared = 1'b1; cyc(3); chk(1'b0, "R10");
    shared = 1'b0; stop_cond(); cyc(3 + TBUF); chk(1'b1, "R4");

    cyc(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule